// File: doc/BRIEF.md
# Serial Byte Memory Slave with Row Activation Pulses

This block is a mode-0 serial peripheral slave in front of a byte-wide storage array. The master pulls the active-low select low, clocks in an 8-bit command, then a 16-bit address field, then any number of data bytes. All fields travel most significant bit first. A write-enable command arms a latch. A later write command stores the incoming bytes at rising addresses, and a read command streams stored bytes back on the serial output. The serial clock, data and select inputs are oversampled in the system clock domain, so the system clock must run at least four times faster than the serial clock.

The array is organized as rows of eight bytes. Address bits above the low three pick the row, and the low three bits pick the byte within it. Each time an access lands in a row other than the one last touched in the current frame, the block raises a one-cycle pulse together with the row number. Logic outside the block can then keep endurance-style activation counts. The address width is a parameter: the default gives 2048 bytes, and a 13-bit setting gives 8192 bytes with 1024 rows.

Top module: `spiRowMem`

## Requirements
- R1: After reset, soEn and rowPulse are low.
- R2: Command 8'h06 sets a write-enable latch. Command 8'h02, in a later frame, stores each complete data byte at the loaded address and then at consecutive addresses, but only while that latch is set.
- R3: The latch clears when any frame that began with 8'h02 ends. A following 8'h02 frame with no new 8'h06 stores nothing.
- R4: Command 8'h03 returns the byte at the loaded address, then the following bytes, on soOut, MSB first. soOut changes only after falling serial clock edges, and the first data bit appears after the falling edge that ends the last address bit.
- R5: Only the low ADDR_W bits of the 16-bit address field are used. The upper bits have no effect.
- R6: During a burst, the address increments after each byte and wraps from the top address to 0.
- R7: Row = address >> 3. A pulse fires for the first access of a frame and whenever an access reaches a different row. Further bytes in the same row give no pulse. A read also fetches the byte after the last one transferred, and that fetch counts as an access.
- R8: Crossing a row boundary, including the wrap from the top row to row 0, produces a new pulse.
- R9: Raising select in the middle of a byte aborts the command. The partial byte is not stored.
- R10: An op-code other than 8'h02, 8'h03 or 8'h06 makes the rest of the frame ignored: nothing is stored, soEn stays low and no pulse fires.
- R11: soEn is high only in the data phase of a read frame, and is low whenever select is high.
- R12: rowPulse lasts exactly one system clock, and rowIdx holds the activated row number while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| sckIn | input | 1 | Serial clock from master (asynchronous) |
| siIn | input | 1 | Serial data from master |
| csNIn | input | 1 | Active-low frame select |
| soOut | output | 1 | Serial data to master |
| soEn | output | 1 | Output enable for soOut |
| rowPulse | output | 1 | One-cycle row activation strobe |
| rowIdx | output | ADDR_W-3 | Row number of the activation |

## Verification
The assertions check on every cycle that the address steps by exactly one per burst byte and that the latch is armed only by a decoded enable command. They also check that an ignored frame issues no store or fetch, that a new frame never begins with the output enabled, and that the row strobe is never wider than one cycle. Stored contents, wrap-around, activation counts for each start offset and burst length, and the effect of aborted bytes or a cleared latch can only be seen through the bench's serial frames. The bench compares these against a byte model and row arithmetic.

// File: rtl/spiRowMem_pkg.sv
package spiRowMem_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRITE = 8'h02;
  localparam logic [7:0] OP_READ  = 8'h03;
  localparam int BYTE_SEL_W = 3;

  typedef enum logic [2:0] {
    PH_OPC, PH_AHI, PH_ALO, PH_DATA, PH_SKIP
  } phase_t;

  typedef struct packed {
    logic frameStart;
    logic addrLoad;
    logic addrInc;
    logic wrByte;
    logic rdLoad;
    logic shiftOut;
  } ctlStrb_t;
endpackage

// File: rtl/spiRowMem_sync.sv
module spiRowMem_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic siIn,
  input  logic csNIn,
  output logic sckRise,
  output logic sckFall,
  output logic siS,
  output logic csActive,
  output logic csStart
);
  logic [SYNC_STAGES:0]   sckPipe;
  logic [SYNC_STAGES:0]   csPipe;
  logic [SYNC_STAGES-1:0] siPipe;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckPipe <= '0;
      csPipe  <= '1;
      siPipe  <= '0;
    end else begin
      sckPipe <= {sckPipe[SYNC_STAGES-1:0], sckIn};
      csPipe  <= {csPipe[SYNC_STAGES-1:0], csNIn};
      siPipe  <= {siPipe[SYNC_STAGES-2:0], siIn};
    end
  end

  assign csActive = !csPipe[SYNC_STAGES-1];
  assign csStart  = csPipe[SYNC_STAGES] && !csPipe[SYNC_STAGES-1];
  assign sckRise  = sckPipe[SYNC_STAGES-1] && !sckPipe[SYNC_STAGES];
  assign sckFall  = !sckPipe[SYNC_STAGES-1] && sckPipe[SYNC_STAGES];
  assign siS      = siPipe[SYNC_STAGES-1];
endmodule

// File: rtl/spiRowMem_ctrl.sv
module spiRowMem_ctrl
  import spiRowMem_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sckRise,
  input  logic              sckFall,
  input  logic              siS,
  input  logic              csActive,
  input  logic              csStart,
  output ctlStrb_t          strb,
  output logic [ADDR_W-1:0] addrField,
  output logic [7:0]        rxByte,
  output logic              soEn
);
  localparam int HI_W = (ADDR_W > 8) ? ADDR_W - 8 : 1;

  phase_t          phase;
  logic [2:0]      bitCnt;
  logic [6:0]      rxShift;
  logic [HI_W-1:0] addrHi;
  logic            welQ;
  logic            isWrite;
  logic            isRead;
  logic            rdPend;
  logic            byteDone;
  logic [7:0]      newByte;

  assign newByte  = {rxShift, siS};
  assign byteDone = csActive && sckRise && (bitCnt == 3'd7);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= PH_OPC;
      bitCnt  <= '0;
      rxShift <= '0;
      addrHi  <= '0;
      welQ    <= 1'b0;
      isWrite <= 1'b0;
      isRead  <= 1'b0;
      rdPend  <= 1'b0;
    end else if (!csActive) begin
      phase   <= PH_OPC;
      bitCnt  <= '0;
      if (isWrite) welQ <= 1'b0;
      isWrite <= 1'b0;
      isRead  <= 1'b0;
      rdPend  <= 1'b0;
    end else begin
      rdPend <= byteDone && isRead && (phase == PH_ALO || phase == PH_DATA);
      if (sckRise) begin
        rxShift <= newByte[6:0];
        bitCnt  <= bitCnt + 3'd1;
      end
      if (byteDone) begin
        unique case (phase)
          PH_OPC: begin
            if (newByte == OP_WREN) begin
              welQ  <= 1'b1;
              phase <= PH_SKIP;
            end else if (newByte == OP_WRITE) begin
              isWrite <= 1'b1;
              phase   <= PH_AHI;
            end else if (newByte == OP_READ) begin
              isRead <= 1'b1;
              phase  <= PH_AHI;
            end else begin
              phase <= PH_SKIP;
            end
          end
          PH_AHI: begin
            addrHi <= newByte[HI_W-1:0];
            phase  <= PH_ALO;
          end
          PH_ALO:  phase <= PH_DATA;
          default: ;
        endcase
      end
    end
  end

  generate
    if (ADDR_W > 8) begin : gWideAddr
      assign addrField = {addrHi, newByte};
    end else begin : gNarrowAddr
      assign addrField = newByte[ADDR_W-1:0];
    end
  endgenerate

  always_comb begin
    strb            = '0;
    strb.frameStart = csStart;
    strb.addrLoad   = byteDone && (phase == PH_ALO);
    strb.wrByte     = byteDone && (phase == PH_DATA) && isWrite && welQ;
    strb.addrInc    = byteDone && (phase == PH_DATA) && (isRead || (isWrite && welQ));
    strb.rdLoad     = rdPend && csActive;
    strb.shiftOut   = sckFall && csActive && (phase == PH_DATA) && isRead;
  end

  assign rxByte = newByte;
  assign soEn   = csActive && isRead && (phase == PH_DATA);

  // R2
  wel_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(welQ) |-> phase == PH_SKIP);
  // R10
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_SKIP |-> !(strb.wrByte || strb.addrInc || strb.rdLoad));
  // R11
  so_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csStart |-> !soEn);
endmodule

// File: rtl/spiRowMem_dp.sv
module spiRowMem_dp
  import spiRowMem_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrb_t          strb,
  input  logic [ADDR_W-1:0] addrField,
  input  logic [7:0]        rxByte,
  output logic              soOut,
  output logic              rowPulse,
  output logic [ADDR_W-BYTE_SEL_W-1:0] rowIdx
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int ROW_W = ADDR_W - BYTE_SEL_W;

  logic [7:0]        mem [DEPTH];
  logic [ADDR_W-1:0] addrQ;
  logic [7:0]        outShift;
  logic [ROW_W-1:0]  lastRow;
  logic [ROW_W-1:0]  curRow;
  logic              rowValid;
  logic              access;

  assign curRow = addrQ[ADDR_W-1:BYTE_SEL_W];
  assign access = strb.wrByte || strb.rdLoad;

  always_ff @(posedge clk) begin
    if (strb.wrByte) mem[addrQ] <= rxByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ    <= '0;
      outShift <= '0;
      soOut    <= 1'b0;
    end else begin
      if (strb.addrLoad)     addrQ <= addrField;
      else if (strb.addrInc) addrQ <= addrQ + 1'b1;
      if (strb.rdLoad) outShift <= mem[addrQ];
      else if (strb.shiftOut) begin
        soOut    <= outShift[7];
        outShift <= {outShift[6:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastRow  <= '0;
      rowValid <= 1'b0;
      rowPulse <= 1'b0;
      rowIdx   <= '0;
    end else begin
      rowPulse <= access && (!rowValid || curRow != lastRow);
      if (strb.frameStart) rowValid <= 1'b0;
      else if (access) begin
        rowValid <= 1'b1;
        lastRow  <= curRow;
        rowIdx   <= curRow;
      end
    end
  end

  // R6
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.addrInc |=> addrQ == ADDR_W'($past(addrQ) + 1'b1));
  // R12
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    rowPulse |=> !rowPulse);
endmodule

// File: rtl/spiRowMem.sv
module spiRowMem
  import spiRowMem_pkg::*;
#(
  parameter int ADDR_W      = 11,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sckIn,
  input  logic siIn,
  input  logic csNIn,
  output logic soOut,
  output logic soEn,
  output logic rowPulse,
  output logic [ADDR_W-4:0] rowIdx
);
  logic              sckRise;
  logic              sckFall;
  logic              siS;
  logic              csActive;
  logic              csStart;
  ctlStrb_t          strb;
  logic [ADDR_W-1:0] addrField;
  logic [7:0]        rxByte;

  spiRowMem_sync #(.SYNC_STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .sckIn(sckIn), .siIn(siIn), .csNIn(csNIn),
    .sckRise(sckRise), .sckFall(sckFall), .siS(siS),
    .csActive(csActive), .csStart(csStart)
  );

  spiRowMem_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sckRise(sckRise), .sckFall(sckFall),
    .siS(siS), .csActive(csActive), .csStart(csStart),
    .strb(strb), .addrField(addrField), .rxByte(rxByte), .soEn(soEn)
  );

  spiRowMem_dp #(.ADDR_W(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .addrField(addrField),
    .rxByte(rxByte), .soOut(soOut), .rowPulse(rowPulse), .rowIdx(rowIdx)
  );
endmodule

// File: tb/sim_spiRowMem.sv
`timescale 1ns/1ps
module sim_spiRowMem;
  localparam int AW   = 8;
  localparam int SZ   = 1 << AW;
  localparam int HALF = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sck = 1'b0;
  logic si = 1'b0;
  logic csN = 1'b1;
  logic so, soEn, rowPulse;
  logic [AW-4:0] rowIdx;

  int compared = 0;
  int mismatched = 0;
  int pulseTotal = 0;
  int wideCnt = 0;
  int frameStartCnt = 0;
  int framePulses = 0;
  logic prevPulse = 1'b0;
  logic [AW-4:0] lastIdx = '0;
  logic [7:0] model [SZ];

  always #4 clk = ~clk;

  spiRowMem #(.ADDR_W(AW)) u0 (
    .clk(clk), .rstN(rstN), .sckIn(sck), .siIn(si), .csNIn(csN),
    .soOut(so), .soEn(soEn), .rowPulse(rowPulse), .rowIdx(rowIdx)
  );

  always @(posedge clk) begin
    prevPulse <= rowPulse;
    if (rowPulse) begin
      pulseTotal <= pulseTotal + 1;
      lastIdx <= rowIdx;
    end
    if (rowPulse && prevPulse) wideCnt <= wideCnt + 1;
  end

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int a, input int seed);
    return 8'((a * 37 + seed * 11 + 5) & 255);
  endfunction

  task automatic spiBits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int b = 7; b > 7 - n; b--) begin
      si = tx[b];
      repeat (HALF) @(negedge clk);
      rx[b] = so;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic spiByte(input logic [7:0] tx, output logic [7:0] rx);
    spiBits(tx, 8, rx);
  endtask

  task automatic csOn();
    @(negedge clk);
    frameStartCnt = pulseTotal;
    csN = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic csOff();
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (8) @(negedge clk);
    framePulses = pulseTotal - frameStartCnt;
  endtask

  task automatic doWren();
    logic [7:0] rx;
    csOn();
    spiByte(8'h06, rx);
    csOff();
  endtask

  task automatic writeBurst(input logic [15:0] a, input int n, input int seed, input bit honoured);
    logic [7:0] rx;
    csOn();
    spiByte(8'h02, rx);
    spiByte(a[15:8], rx);
    spiByte(a[7:0], rx);
    for (int i = 0; i < n; i++) begin
      int ad;
      ad = (int'(a) + i) % SZ;
      spiByte(pat(ad, seed), rx);
      if (honoured) model[ad] = pat(ad, seed);
    end
    csOff();
  endtask

  task automatic readBurst(input logic [15:0] a, input int n, input string req);
    logic [7:0] rx;
    csOn();
    spiByte(8'h03, rx);
    spiByte(a[15:8], rx);
    spiByte(a[7:0], rx);
    for (int i = 0; i < n; i++) begin
      int ad;
      ad = (int'(a) + i) % SZ;
      spiByte(8'h00, rx);
      chk(req, rx, model[ad]);
      if (i == 0) chk("R11 soEn in read data", soEn, 1);
    end
    csOff();
    chk("R11 soEn after frame", soEn, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] rx;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 soEn", soEn, 0);
    chk("R1 rowPulse", rowPulse, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 soEn after release", soEn, 0);

    // R2 R5: fill whole array, upper address bits set
    doWren();
    writeBurst(16'hE000, SZ, 3, 1'b1);
    chk("R7 fill pulses", framePulses, SZ / 8);
    // R4 R6 R8: full read, prefetch wraps back to row 0
    readBurst(16'h0000, SZ, "R4 full read");
    chk("R8 full read pulses", framePulses, SZ / 8 + 1);
    chk("R12 last row idx", lastIdx, 0);

    // R3: write with no prior enable
    writeBurst(16'h000A, 1, 9, 1'b0);
    chk("R3 no-enable pulses", framePulses, 0);
    readBurst(16'h000A, 1, "R3 unchanged");
    // R3: latch cleared by a write frame
    doWren();
    writeBurst(16'h0020, 2, 4, 1'b1);
    writeBurst(16'h0020, 2, 6, 1'b0);
    readBurst(16'h0020, 2, "R3 latch cleared");

    // R6 R8: write burst across top address
    doWren();
    writeBurst(16'h7AFE, 4, 7, 1'b1);
    chk("R8 wrap write pulses", framePulses, 2);
    chk("R12 wrap row idx", lastIdx, 0);
    readBurst(16'h00FC, 8, "R6 wrap read");
    chk("R8 wrap read pulses", framePulses, 2);

    // R7: sweep start offset and length inside rows
    for (int s = 0; s < 8; s++) begin
      for (int n = 1; n <= 8; n++) begin
        readBurst(16'(16'h0040 + s), n, "R7 sweep data");
        chk("R7 sweep pulses", framePulses, ((s + n) >> 3) - (s >> 3) + 1);
      end
    end

    // R9: aborted byte
    doWren();
    csOn();
    spiByte(8'h02, rx);
    spiByte(8'h00, rx);
    spiByte(8'h40, rx);
    spiByte(8'h11, rx);
    model[8'h40] = 8'h11;
    spiBits(8'hC3, 4, rx);
    csOff();
    readBurst(16'h0040, 2, "R9 partial byte discarded");

    // R10: unknown op-code
    csOn();
    spiByte(8'h05, rx);
    spiByte(8'h00, rx);
    spiByte(8'h30, rx);
    chk("R10 soEn low", soEn, 0);
    spiByte(8'hEE, rx);
    csOff();
    chk("R10 pulses", framePulses, 0);
    readBurst(16'h0030, 1, "R10 unchanged");

    chk("R12 pulse width", wideCnt, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule